// File: doc/BRIEF.md
# Scratchpad-Mapped Memory Access Unit

This unit connects a 32-bit processor data port to two places where data can live. The first is a small on-chip scratchpad SRAM. It sits in a fixed, size-aligned address window and always answers in a single cycle. The second is an external main memory, reached over a simple bus whose latency is fixed by the transfer width. The unit selects the target from the request address alone. There is no tag store, no comparator against tags and no hit or miss indication.

A request is offered with `req_valid_i` and is taken on a clock edge where `req_ready_o` is high. Scratchpad requests finish one cycle later. Main-memory requests hold `req_ready_o` low while the external bus runs its wait cycles, then finish with a one-cycle `rsp_done_o` pulse. A read carries its data on `rsp_rdata_o` in that same cycle. A 32-bit counter adds up the cycle cost of every finished access. Profiling code can read it and clear it.

Top module: `spm_access_unit`

## Requirements
- R1: An address whose bits [31:12] equal those of `SPM_BASE` (default 0x1000_0000, 4 KB window) goes to the scratchpad and never raises `ext_req_o`. Every other address goes to the external bus.
- R2: A scratchpad request accepted at edge k shows `rsp_done_o` high in the cycle after edge k. `req_ready_o` stays high throughout, so scratchpad requests may be issued back to back.
- R3: A main-memory request with `req_wide_i`=0 (16-bit) raises `ext_req_o` for exactly one cycle. `rsp_done_o` rises in the second cycle after acceptance, and `req_ready_o` is low while `ext_req_o` is high.
- R4: A main-memory request with `req_wide_i`=1 (32-bit) raises `ext_req_o` for exactly three cycles, and `rsp_done_o` rises in the fourth cycle after acceptance.
- R5: A scratchpad write updates only the byte lanes whose `req_be_i` bit is set (bit n covers data bits [8n+7:8n]). A later read returns the merged word.
- R6: A main-memory read returns `ext_rdata_i` as sampled in the last `ext_req_o` cycle. A 16-bit read returns its low half with bits [31:16] forced to zero.
- R7: While `ext_req_o` is high, `ext_addr_o`, `ext_wdata_o`, `ext_we_o` and `ext_wide_o` hold the values of the accepted request.
- R8: On the edge that closes a done cycle, `cycle_cnt_o` grows by that access's cost: 1 for the scratchpad, 2 for a 16-bit access, 4 for a 32-bit access.
- R9: `cnt_clr_i` high at an edge sets `cycle_cnt_o` to zero, and this wins over an addition at the same edge.
- R10: After reset, `req_ready_o` is high, `rsp_done_o` and `ext_req_o` are low and `cycle_cnt_o` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request offered |
| req_ready_o | output | 1 | Request can be taken this cycle |
| req_we_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | 32 | Byte address |
| req_wdata_i | input | 32 | Write data |
| req_be_i | input | 4 | Byte lane enables for scratchpad writes |
| req_wide_i | input | 1 | Main-memory width: 1 = 32-bit, 0 = 16-bit |
| rsp_done_o | output | 1 | One-cycle completion pulse |
| rsp_rdata_o | output | 32 | Read data, valid with rsp_done_o on reads |
| ext_req_o | output | 1 | External bus access in progress |
| ext_we_o | output | 1 | External write |
| ext_addr_o | output | 32 | External byte address |
| ext_wdata_o | output | 32 | External write data |
| ext_wide_o | output | 1 | External transfer width, 1 = 32-bit |
| ext_rdata_i | input | 32 | External read data |
| cnt_clr_i | input | 1 | Synchronous clear of the cycle counter |
| cycle_cnt_o | output | 32 | Accumulated access cycles |

## Verification
The assertions assume that the request fields stay meaningful only at an accepting edge. They also assume that the external memory presents read data by the last `ext_req_o` cycle, because the unit samples the bus there and never waits longer. The stimulus changes inputs only on falling edges. It reads scratchpad words only after they have been written in full, so no unknown SRAM content reaches a compared output. It models the external memory as a fixed function of `ext_addr_o`, so the expected read data follows directly from the address that was offered.

// File: rtl/spm_pkg.sv
package spm_pkg;
  typedef enum logic {
    SEQ_IDLE = 1'b0,
    SEQ_WAIT = 1'b1
  } seq_state_e;

  typedef struct packed {
    logic [31:0] addr;
    logic [31:0] wdata;
    logic        we;
    logic        wide;
  } ext_cmd_t;
endpackage

// File: rtl/spm_window_decode.sv
module spm_window_decode #(
  parameter int              AW        = 32,
  parameter int              OFF_W     = 2,
  parameter int              IW        = 10,
  parameter logic [AW-1:0]   SPM_BASE  = 32'h1000_0000
) (
  input  logic [AW-OFF_W-1:0] word_addr_i,
  output logic                hit_o,
  output logic [IW-1:0]       idx_o
);
  localparam int TAG_W = AW - OFF_W - IW;
  localparam logic [TAG_W-1:0] BASE_TAG = SPM_BASE[AW-1:OFF_W+IW];

  assign hit_o = (word_addr_i[AW-OFF_W-1:IW] == BASE_TAG);
  assign idx_o = word_addr_i[IW-1:0];
endmodule

// File: rtl/spm_sram.sv
module spm_sram #(
  parameter int DEPTH = 1024,
  parameter int DW    = 32,
  localparam int IW   = $clog2(DEPTH),
  localparam int BW   = DW / 8
) (
  input  logic          clk_i,
  input  logic          en_i,
  input  logic          we_i,
  input  logic [IW-1:0] idx_i,
  input  logic [BW-1:0] be_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o
);
  logic [DW-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (en_i) begin
      if (we_i) begin
        for (int b = 0; b < BW; b++) begin
          if (be_i[b]) mem_q[idx_i][8*b +: 8] <= wdata_i[8*b +: 8];
        end
      end else begin
        rdata_o <= mem_q[idx_i];
      end
    end
  end
endmodule

// File: rtl/ext_bus_seq.sv
module ext_bus_seq
  import spm_pkg::*;
#(
  parameter int DW        = 32,
  parameter int WAIT_HALF = 1,
  parameter int WAIT_FULL = 3,
  localparam int CW       = $clog2(WAIT_FULL + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  ext_cmd_t      cmd_i,
  output logic          busy_o,
  output logic          done_o,
  output logic [DW-1:0] rdata_o,
  output ext_cmd_t      cmd_o,
  input  logic [DW-1:0] ext_rdata_i
);
  localparam int HW = DW / 2;

  seq_state_e    state_q;
  logic [CW-1:0] wcnt_q;
  logic          done_q;
  logic [DW-1:0] rdata_q;
  ext_cmd_t      cmd_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= SEQ_IDLE;
      wcnt_q  <= '0;
      done_q  <= 1'b0;
      rdata_q <= '0;
      cmd_q   <= '0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        SEQ_IDLE: begin
          if (start_i) begin
            state_q <= SEQ_WAIT;
            cmd_q   <= cmd_i;
            wcnt_q  <= cmd_i.wide ? CW'(WAIT_FULL) : CW'(WAIT_HALF);
          end
        end
        SEQ_WAIT: begin
          if (wcnt_q == CW'(1)) begin
            state_q <= SEQ_IDLE;
            done_q  <= 1'b1;
            rdata_q <= cmd_q.wide ? ext_rdata_i : {{HW{1'b0}}, ext_rdata_i[HW-1:0]};
          end else begin
            wcnt_q <= wcnt_q - CW'(1);
          end
        end
        default: state_q <= SEQ_IDLE;
      endcase
    end
  end

  assign busy_o  = (state_q == SEQ_WAIT);
  assign done_o  = done_q;
  assign rdata_o = rdata_q;
  assign cmd_o   = cmd_q;

  p_cmd_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && $past(busy_o) |-> $stable(cmd_o));
  p_done_idle_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);
endmodule

// File: rtl/access_cycle_counter.sv
module access_cycle_counter #(
  parameter int CNT_W = 32,
  parameter int LAT_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             add_en_i,
  input  logic [LAT_W-1:0] add_val_i,
  output logic [CNT_W-1:0] cnt_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       cnt_o <= '0;
    else if (clr_i)    cnt_o <= '0;
    else if (add_en_i) cnt_o <= cnt_o + CNT_W'(add_val_i);
  end

  p_clear_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (cnt_o == '0));
  p_accum_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_i && add_en_i |=> (cnt_o == $past(cnt_o) + CNT_W'($past(add_val_i))));
  p_idle_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_i && !add_en_i |=> $stable(cnt_o));
endmodule

// File: rtl/spm_access_unit.sv
module spm_access_unit
  import spm_pkg::*;
#(
  parameter int          SPM_BYTES = 4096,
  parameter logic [31:0] SPM_BASE  = 32'h1000_0000,
  parameter int          WAIT_HALF = 1,
  parameter int          WAIT_FULL = 3,
  parameter int          CNT_W     = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_valid_i,
  output logic             req_ready_o,
  input  logic             req_we_i,
  input  logic [31:0]      req_addr_i,
  input  logic [31:0]      req_wdata_i,
  input  logic [3:0]       req_be_i,
  input  logic             req_wide_i,
  output logic             rsp_done_o,
  output logic [31:0]      rsp_rdata_o,
  output logic             ext_req_o,
  output logic             ext_we_o,
  output logic [31:0]      ext_addr_o,
  output logic [31:0]      ext_wdata_o,
  output logic             ext_wide_o,
  input  logic [31:0]      ext_rdata_i,
  input  logic             cnt_clr_i,
  output logic [CNT_W-1:0] cycle_cnt_o
);
  localparam int AW    = 32;
  localparam int DW    = 32;
  localparam int OFF_W = $clog2(DW / 8);
  localparam int DEPTH = SPM_BYTES / (DW / 8);
  localparam int IW    = $clog2(DEPTH);
  localparam int LAT_W = $clog2(WAIT_FULL + 2) + 1;

  logic          accept, hit;
  logic [IW-1:0] idx;
  logic [DW-1:0] sram_rdata, ext_rdata;
  logic          ext_busy, ext_done;
  logic          spm_done_q, src_spm_q;
  logic [LAT_W-1:0] lat_q;
  ext_cmd_t      cmd_in, cmd_out;

  assign accept = req_valid_i && req_ready_o;

  spm_window_decode #(
    .AW(AW), .OFF_W(OFF_W), .IW(IW), .SPM_BASE(SPM_BASE)
  ) u_decode (
    .word_addr_i(req_addr_i[AW-1:OFF_W]),
    .hit_o      (hit),
    .idx_o      (idx)
  );

  spm_sram #(.DEPTH(DEPTH), .DW(DW)) u_sram (
    .clk_i  (clk_i),
    .en_i   (accept && hit),
    .we_i   (req_we_i),
    .idx_i  (idx),
    .be_i   (req_be_i),
    .wdata_i(req_wdata_i),
    .rdata_o(sram_rdata)
  );

  assign cmd_in = '{addr: req_addr_i, wdata: req_wdata_i, we: req_we_i, wide: req_wide_i};

  ext_bus_seq #(.DW(DW), .WAIT_HALF(WAIT_HALF), .WAIT_FULL(WAIT_FULL)) u_ext (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (accept && !hit),
    .cmd_i      (cmd_in),
    .busy_o     (ext_busy),
    .done_o     (ext_done),
    .rdata_o    (ext_rdata),
    .cmd_o      (cmd_out),
    .ext_rdata_i(ext_rdata_i)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      spm_done_q <= 1'b0;
      src_spm_q  <= 1'b0;
      lat_q      <= '0;
    end else begin
      spm_done_q <= accept && hit;
      if (accept) begin
        src_spm_q <= hit;
        lat_q     <= hit ? LAT_W'(1)
                   : (req_wide_i ? LAT_W'(WAIT_FULL + 1) : LAT_W'(WAIT_HALF + 1));
      end
    end
  end

  access_cycle_counter #(.CNT_W(CNT_W), .LAT_W(LAT_W)) u_cnt (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clr_i    (cnt_clr_i),
    .add_en_i (rsp_done_o),
    .add_val_i(lat_q),
    .cnt_o    (cycle_cnt_o)
  );

  assign req_ready_o = !ext_busy;
  assign rsp_done_o  = spm_done_q || ext_done;
  assign rsp_rdata_o = src_spm_q ? sram_rdata : ext_rdata;
  assign ext_req_o   = ext_busy;
  assign ext_we_o    = cmd_out.we;
  assign ext_addr_o  = cmd_out.addr;
  assign ext_wdata_o = cmd_out.wdata;
  assign ext_wide_o  = cmd_out.wide;

  p_spm_no_ext_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept && hit |=> !ext_req_o);
  p_spm_one_cycle_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept && hit |=> rsp_done_o && req_ready_o);
  p_half_wait_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept && !hit && !req_wide_i |=> ext_req_o && !rsp_done_o ##1 !ext_req_o && rsp_done_o);
  p_full_wait_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept && !hit && req_wide_i |=> ext_req_o ##1 ext_req_o ##1 ext_req_o ##1 (!ext_req_o && rsp_done_o));
  p_busy_not_ready_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ext_req_o |-> !req_ready_o);
endmodule

// File: tb/spm_access_unit_bench.sv
module spm_access_unit_bench;
  localparam int          CLK_PERIOD = 10;
  localparam logic [31:0] BASE       = 32'h1000_0000;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        req_valid = 1'b0, req_we = 1'b0, req_wide = 1'b0, cnt_clr = 1'b0;
  logic [31:0] req_addr = '0, req_wdata = '0;
  logic [3:0]  req_be = '0;
  logic        req_ready, rsp_done, ext_req, ext_we, ext_wide;
  logic [31:0] rsp_rdata, ext_addr, ext_wdata, ext_rdata, cycle_cnt;

  int n_checks = 0, n_fail = 0;
  bit finished = 0;

  function automatic logic [31:0] ext_fn(logic [31:0] a);
    return (a * 32'h9E37_79B1) ^ 32'h5A5A_0F0F;
  endfunction

  assign ext_rdata = ext_fn(ext_addr);

  always #(CLK_PERIOD / 2) clk = ~clk;

  spm_access_unit u_spm_access_unit (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_ready_o(req_ready),
    .req_we_i(req_we), .req_addr_i(req_addr), .req_wdata_i(req_wdata), .req_be_i(req_be),
    .req_wide_i(req_wide), .rsp_done_o(rsp_done), .rsp_rdata_o(rsp_rdata),
    .ext_req_o(ext_req), .ext_we_o(ext_we), .ext_addr_o(ext_addr), .ext_wdata_o(ext_wdata),
    .ext_wide_o(ext_wide), .ext_rdata_i(ext_rdata), .cnt_clr_i(cnt_clr), .cycle_cnt_o(cycle_cnt)
  );

  // behavioural reference
  int          m_rem, m_lat;
  bit          m_done, m_rd, m_spm, m_pwe, m_pwide, m_clr_prev;
  logic [31:0] m_rdata, m_cnt, m_paddr, m_pwdata;
  logic [31:0] mem [int];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_rem = 0; m_lat = 0; m_done = 0; m_rd = 0; m_spm = 0; m_cnt = 0; m_clr_prev = 0;
      m_pwe = 0; m_pwide = 0; m_paddr = 0; m_pwdata = 0; m_rdata = 0;
    end else begin
      m_clr_prev = cnt_clr;
      if (cnt_clr) m_cnt = 0;
      else if (m_done) m_cnt = m_cnt + 32'(m_lat);
      m_done = 0;
      if (m_rem > 0) begin
        m_rem--;
        if (m_rem == 0) begin
          logic [31:0] w;
          w = ext_fn(m_paddr);
          m_done = 1; m_spm = 0; m_rd = !m_pwe;
          m_rdata = m_pwide ? w : {16'h0, w[15:0]};
        end
      end else if (req_valid) begin
        if (req_addr[31:12] == BASE[31:12]) begin
          int i;
          i = int'(req_addr[11:2]);
          m_done = 1; m_spm = 1; m_lat = 1; m_rd = !req_we;
          if (req_we) begin
            if (!mem.exists(i)) mem[i] = 'x;
            for (int b = 0; b < 4; b++) if (req_be[b]) mem[i][8*b +: 8] = req_wdata[8*b +: 8];
          end else m_rdata = mem[i];
        end else begin
          m_rem = req_wide ? 3 : 1; m_lat = req_wide ? 4 : 2;
          m_paddr = req_addr; m_pwe = req_we; m_pwide = req_wide; m_pwdata = req_wdata;
        end
      end
    end
  end

  task automatic check(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !finished) begin
      string t;
      t = (m_lat == 1) ? "R2" : (m_lat == 2 ? "R3" : "R4");
      check(req_ready === (m_rem == 0), {t, " ready"}, 32'(req_ready), 32'(m_rem == 0));
      check(rsp_done === m_done, {t, " done"}, 32'(rsp_done), 32'(m_done));
      check(ext_req === (m_rem > 0), "R1 ext_req", 32'(ext_req), 32'(m_rem > 0));
      if (m_done && m_rd)
        check(rsp_rdata === m_rdata, m_spm ? "R5 spm rdata" : "R6 ext rdata", rsp_rdata, m_rdata);
      if (m_rem > 0) begin
        check(ext_addr === m_paddr, "R7 addr", ext_addr, m_paddr);
        check(ext_wdata === m_pwdata, "R7 wdata", ext_wdata, m_pwdata);
        check({ext_we, ext_wide} === {m_pwe, m_pwide}, "R7 ctl",
              32'({ext_we, ext_wide}), 32'({m_pwe, m_pwide}));
      end
      check(cycle_cnt === m_cnt, m_clr_prev ? "R9 counter" : "R8 counter", cycle_cnt, m_cnt);
    end
  end

  // entered and left at a falling edge
  task automatic issue(logic [31:0] a, bit we, logic [31:0] d, logic [3:0] be, bit wide);
    req_valid = 1; req_addr = a; req_we = we; req_wdata = d; req_be = be; req_wide = wide;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    idle(2);
    check(req_ready === 1'b1, "R10 ready", 32'(req_ready), 1);
    check(rsp_done === 1'b0, "R10 done", 32'(rsp_done), 0);
    check(ext_req === 1'b0, "R10 ext_req", 32'(ext_req), 0);
    check(cycle_cnt === 32'h0, "R10 counter", cycle_cnt, 0);
    rst_n = 1;
    idle(1);
    // R2: back-to-back full writes, window low and high edges
    for (int k = 0; k < 8; k++) issue(BASE + 32'(4*k), 1, 32'hA000_0000 + 32'(k*32'h1111), 4'hF, 0);
    issue(BASE + 32'hFFC, 1, 32'hDEAD_BEEF, 4'hF, 1);
    for (int k = 0; k < 8; k++) issue(BASE + 32'(4*k), 0, 0, 4'hF, 0);
    issue(BASE + 32'hFFC, 0, 0, 4'hF, 0);
    // R5: partial lane writes
    issue(BASE + 32'h4, 1, 32'h1122_3344, 4'b0101, 0);
    issue(BASE + 32'h8, 1, 32'h5566_7788, 4'b1000, 0);
    issue(BASE + 32'hC, 1, 32'h99AA_BBCC, 4'b0000, 0);
    issue(BASE + 32'h4, 0, 0, 4'hF, 0);
    issue(BASE + 32'h8, 0, 0, 4'hF, 0);
    issue(BASE + 32'hC, 0, 0, 4'hF, 0);
    idle(2);
    // R1/R3/R4/R6: just outside the window on both sides
    issue(BASE - 32'h4, 0, 0, 4'hF, 1);
    issue(BASE + 32'h1000, 0, 0, 4'hF, 0);
    issue(32'h0000_0100, 1, 32'hCAFE_F00D, 4'h0, 1);
    issue(32'h8000_0002, 0, 0, 4'hF, 0);
    issue(BASE + 32'h10, 0, 0, 4'hF, 1);
    idle(3);
    // R9: clear alone, then clear on the edge that closes a done cycle
    cnt_clr = 1; idle(1); cnt_clr = 0;
    issue(BASE, 0, 0, 4'hF, 0);
    cnt_clr = 1; idle(1); cnt_clr = 0;
    issue(32'h2000_0000, 0, 0, 4'hF, 1);
    idle(2);
    for (int n = 0; n < 300; n++) begin
      logic [31:0] r, a;
      r = $urandom;
      if (r[0]) a = BASE + {20'h0, 7'h0, r[3:1], 2'b00};
      else a = {r[31:12] ^ 20'h00001, r[11:2], 2'b00};
      issue(a, r[4] && r[0] ? 1'b1 : r[5], $urandom, r[9:6], r[10]);
      if (r[13:11] == 3'd0) cnt_clr = 1;
      if (r[15:14] == 2'd0) idle(1);
      cnt_clr = 0;
    end
    idle(6);
    finish_run();
  end
endmodule